// File: doc/BRIEF.md
# Synchronous Shift Port

This block is the clocked, half-duplex mode of a serial port. It moves one byte at a time over a single data line, and it drives a shift clock on a second pin for the far end to use. The shift clock runs at one twelfth of the system clock. The divisor is a parameter with a default of 12. Bit 0 goes first in both directions.

The data line is open-drain. The block never drives it high. It only asserts `line_pull` to pull the pin low, and an external pull-up supplies the high level. The wired level of the pin comes back on `line_in`.

A write strobe loads a byte and sends it. Reception needs three things: the receive enable is high, the receive-done flag is clear, and the port is idle. Under those conditions the block clocks in eight bits on its own. Each direction has a sticky done flag, and only an explicit clear strobe resets it. A new reception therefore cannot overwrite a byte that has not yet been collected.

Top module: `sync_shift_port`

## Requirements
- R1: After a synchronous reset, the outputs are as follows: `sclk_out` = 1, `line_pull` = 0, `tx_done` = 0, `rx_done` = 0, `busy` = 0 and `rx_data` = 0.
- R2: A write while idle starts a transmission of eight bits, bit 0 first. For each bit, `line_pull` = 1 if the bit is 0 and `line_pull` = 0 if the bit is 1. `line_pull` is 0 whenever the port is idle.
- R3: Each bit lasts 12 system cycles. `sclk_out` is low for the first 6 cycles and high for the last 6. A transfer has exactly 8 rising edges of `sclk_out`. `sclk_out` is high whenever the port is idle.
- R4: Outgoing data changes in the same cycle that `sclk_out` falls. `sclk_out` rises 6 cycles later, in the middle of the bit.
- R5: `tx_done` rises exactly 96 cycles after the clock edge that accepts the write. It then stays high until it is cleared.
- R6: A reception starts when the port is idle, `rx_enable` = 1, `rx_done` = 0 and `wr_en` = 0. The block samples `line_in` at each rising edge of `sclk_out`, bit 0 first. 96 cycles after the start, `rx_data` holds the byte and `rx_done` is set.
- R7: During a reception, `line_pull` stays 0.
- R8: While `rx_done` = 1, no new reception starts, even with `rx_enable` = 1. `sclk_out` stays high and `rx_data` holds its value.
- R9: A write while `busy` = 1 is ignored. The current byte goes out unchanged and no second transfer follows it.
- R10: A pulse on `clr_tx_done` or `clr_rx_done` clears the matching flag in the next cycle.
- R11: If `wr_en` and a valid receive start occur in the same cycle, the transmission wins.
- R12: `busy` rises in the cycle after a start is accepted. It falls in the same cycle that the done flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| rx_enable | input | 1 | Allows a reception to start |
| clr_tx_done | input | 1 | Clears the transmit-done flag |
| clr_rx_done | input | 1 | Clears the receive-done flag |
| line_in | input | 1 | Wired level of the open-drain data pin |
| line_pull | output | 1 | 1 pulls the data pin low; 0 releases it |
| sclk_out | output | 1 | Shift clock, high when idle |
| tx_done | output | 1 | Sticky transmit-done flag |
| rx_done | output | 1 | Sticky receive-done flag |
| rx_data | output | 8 | Last received byte |
| busy | output | 1 | A transfer is in progress |

## Verification
The hardest cases to reach from the ports depend on timing between inputs. One is a write that arrives in the middle of a transfer. Another is a write that lands in the same cycle as a valid receive start. A third is a receive enable held high after a byte arrives, which must not start a new reception.

The bench reaches each of these cases with directed timing. It strobes a second write 20 cycles into a transmission. It raises `wr_en` and `rx_enable` on the same edge. After a reception, it leaves `rx_enable` high for several bit times.

A device model on the wired line does two jobs: it captures the bits the block sends on each clock rise, and it presents bits for the block to receive on each clock fall. Both random and directed bytes pass through this model.

// File: rtl/sync_shift_pkg.sv
package sync_shift_pkg;
  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_TX   = 2'd1,
    SS_RX   = 2'd2
  } ss_mode_e;
endpackage

// File: rtl/ssp_clkgen.sv
// Bit-phase counter and shift clock generator.
// Phases 0..HALF-1: clock low. Phases HALF..DIV-1: clock high.
module ssp_clkgen #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  input  logic last_bit,
  output logic sclk,
  output logic rise_tick,
  output logic end_tick
);
  localparam int HALF = DIV / 2;
  localparam int PH_W = $clog2(DIV);

  logic [PH_W-1:0] phase;

  assign rise_tick = run && (phase == PH_W'(HALF - 1));
  assign end_tick  = run && (phase == PH_W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      sclk  <= 1'b1;
    end else if (start) begin
      phase <= '0;
      sclk  <= 1'b0;
    end else if (run) begin
      if (end_tick) begin
        phase <= '0;
        sclk  <= last_bit;
      end else begin
        phase <= phase + PH_W'(1);
        if (rise_tick) sclk <= 1'b1;
      end
    end else begin
      phase <= '0;
      sclk  <= 1'b1;
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (phase <= PH_W'(DIV - 1))); // R3
  AST_LOW_FIRST_HALF: assert property (@(posedge clk) disable iff (rst)
    (run && phase < PH_W'(HALF)) |-> !sclk); // R3
  AST_HIGH_SECOND_HALF: assert property (@(posedge clk) disable iff (rst)
    (run && phase >= PH_W'(HALF)) |-> sclk); // R4
endmodule

// File: rtl/ssp_ctrl.sv
// Transfer sequencing, bit counting and sticky completion flags.
module ssp_ctrl
  import sync_shift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  logic     rx_enable,
  input  logic     clr_tx,
  input  logic     clr_rx,
  input  logic     end_tick,
  output ss_mode_e mode,
  output logic     start_tx,
  output logic     start_rx,
  output logic     last_bit,
  output logic     fin,
  output logic     done_rx,
  output logic     tx_done,
  output logic     rx_done,
  output logic     busy
);
  localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [BC_W-1:0] bitcnt;
  logic            idle;
  logic            done_tx;

  assign idle     = (mode == SS_IDLE);
  // A write takes priority over a pending receive start.
  assign start_tx = idle && wr_en;
  assign start_rx = idle && !wr_en && rx_enable && !rx_done;
  assign last_bit = (bitcnt == BC_W'(DATA_W - 1));
  assign fin      = end_tick && last_bit;
  assign done_tx  = fin && (mode == SS_TX);
  assign done_rx  = fin && (mode == SS_RX);
  assign busy     = !idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= SS_IDLE;
      bitcnt <= '0;
    end else begin
      if (start_tx) begin
        mode   <= SS_TX;
        bitcnt <= '0;
      end else if (start_rx) begin
        mode   <= SS_RX;
        bitcnt <= '0;
      end else if (fin) begin
        mode   <= SS_IDLE;
        bitcnt <= '0;
      end else if (end_tick) begin
        bitcnt <= bitcnt + BC_W'(1);
      end
    end
  end

  // A setting event wins over a clear strobe in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      if (done_tx)     tx_done <= 1'b1;
      else if (clr_tx) tx_done <= 1'b0;
      if (done_rx)     rx_done <= 1'b1;
      else if (clr_rx) rx_done <= 1'b0;
    end
  end

  AST_TX_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !clr_tx) |=> tx_done); // R5
  AST_TX_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_tx && !done_tx) |=> !tx_done); // R10
  AST_RX_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_rx && !done_rx) |=> !rx_done); // R10
  AST_NO_RX_WHILE_FULL: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !clr_rx && idle) |=> (mode != SS_RX)); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (idle && wr_en) |=> (mode == SS_TX)); // R11
endmodule

// File: rtl/ssp_shifter.sv
// Shared shift register, open-drain pull control and receive holding register.
module ssp_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_tx,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              clear_rx,
  input  logic              tx_shift,
  input  logic              rx_capture,
  input  logic              release_line,
  input  logic              rx_commit,
  input  logic              line_in,
  output logic              line_pull,
  output logic [DATA_W-1:0] rx_data
);
  logic [DATA_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg      <= '0;
      line_pull <= 1'b0;
    end else if (load_tx) begin
      sreg      <= tx_byte;
      line_pull <= ~tx_byte[0];
    end else if (clear_rx) begin
      sreg      <= '0;
      line_pull <= 1'b0;
    end else if (release_line) begin
      line_pull <= 1'b0;
    end else if (tx_shift) begin
      sreg      <= sreg >> 1;
      line_pull <= ~sreg[1];
    end else if (rx_capture) begin
      sreg      <= {line_in, sreg[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            rx_data <= '0;
    else if (rx_commit) rx_data <= sreg;
  end

  AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (rst)
    (release_line && !load_tx && !clear_rx) |=> !line_pull); // R2
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import sync_shift_pkg::*;
#(
  parameter int DIV    = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rx_enable,
  input  logic              clr_tx_done,
  input  logic              clr_rx_done,
  input  logic              line_in,
  output logic              line_pull,
  output logic              sclk_out,
  output logic              tx_done,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy
);
  ss_mode_e mode;
  logic start_tx, start_rx, last_bit, fin, done_rx;
  logic rise_tick, end_tick;

  ssp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rx_enable (rx_enable),
    .clr_tx    (clr_tx_done),
    .clr_rx    (clr_rx_done),
    .end_tick  (end_tick),
    .mode      (mode),
    .start_tx  (start_tx),
    .start_rx  (start_rx),
    .last_bit  (last_bit),
    .fin       (fin),
    .done_rx   (done_rx),
    .tx_done   (tx_done),
    .rx_done   (rx_done),
    .busy      (busy)
  );

  ssp_clkgen #(.DIV(DIV)) u_clkgen (
    .clk       (clk),
    .rst       (rst),
    .start     (start_tx || start_rx),
    .run       (busy),
    .last_bit  (last_bit),
    .sclk      (sclk_out),
    .rise_tick (rise_tick),
    .end_tick  (end_tick)
  );

  ssp_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk          (clk),
    .rst          (rst),
    .load_tx      (start_tx),
    .tx_byte      (wr_data),
    .clear_rx     (start_rx),
    .tx_shift     (end_tick && (mode == SS_TX) && !last_bit),
    .rx_capture   (rise_tick && (mode == SS_RX)),
    .release_line (fin),
    .rx_commit    (done_rx),
    .line_in      (line_in),
    .line_pull    (line_pull),
    .rx_data      (rx_data)
  );

  AST_IDLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sclk_out); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !line_pull); // R2
  AST_RX_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (mode == SS_RX) |-> !line_pull); // R7
  AST_RXDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !clr_rx_done) |=> $stable(rx_data)); // R8
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_en) |=> busy); // R12
  AST_BUSY_ENDS_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (tx_done || rx_done)); // R12
endmodule

// File: tb/sync_shift_port_tb.sv
module sync_shift_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 12;
  localparam int W          = 8;
  localparam int XFER       = DIV * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic rx_enable = 1'b0;
  logic clr_tx_done = 1'b0;
  logic clr_rx_done = 1'b0;
  logic line_in;
  logic line_pull, sclk_out, tx_done, rx_done, busy;
  logic [W-1:0] rx_data;

  // external device on the wired line
  logic         dev_active = 1'b0;
  logic [W-1:0] dev_byte = '0;
  logic         dev_out = 1'b1;
  logic [3:0]   dev_idx = '0;
  logic [W-1:0] cap = '0;
  int           rise_cnt = 0;

  int n_chk = 0;
  int n_fail = 0;

  assign line_in = (dev_active ? dev_out : 1'b1) & ~line_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_shift_port #(.DIV(DIV), .DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rx_enable(rx_enable), .clr_tx_done(clr_tx_done), .clr_rx_done(clr_rx_done),
    .line_in(line_in), .line_pull(line_pull), .sclk_out(sclk_out),
    .tx_done(tx_done), .rx_done(rx_done), .rx_data(rx_data), .busy(busy)
  );

  always @(negedge sclk_out) dev_out <= dev_byte[dev_idx[2:0]];
  always @(posedge sclk_out) begin
    cap[dev_idx[2:0]] <= line_in;
    dev_idx <= dev_idx + 4'd1;
    rise_cnt <= rise_cnt + 1;
  end

  function automatic logic exp_pull(input logic [W-1:0] b, input int k);
    return ~b[k];
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic run_tx(input logic [W-1:0] b, input logic with_rx, input int mid, input logic [W-1:0] b2);
    int cnt = 0, low = 0, bad_bit = 0, bad_edge = 0;
    @(negedge clk);
    wr_data = b; wr_en = 1'b1; rx_enable = with_rx;
    dev_active = 1'b0; dev_idx = '0; rise_cnt = 0;
    @(negedge clk);
    wr_en = 1'b0; rx_enable = 1'b0;
    chk(busy == 1'b1, "R12 busy after write", busy, 1);
    while (!tx_done && cnt < 200) begin
      if (!sclk_out) low++;
      if (cnt % DIV == 0 && cnt < XFER && line_pull != exp_pull(b, cnt / DIV)) bad_bit++;
      if (cnt % DIV == DIV/2 - 1 && sclk_out != 1'b0) bad_edge++;
      if (cnt % DIV == DIV/2 && sclk_out != 1'b1) bad_edge++;
      if (cnt == mid) begin wr_data = b2; wr_en = 1'b1; end
      if (cnt == mid + 1) wr_en = 1'b0;
      @(negedge clk);
      cnt++;
    end
    wr_en = 1'b0;
    chk(cnt == XFER, "R5 cycles to tx_done", cnt, XFER);
    chk(low == XFER/2, "R3 clock low cycles", low, XFER/2);
    chk(rise_cnt == W, "R3 rising edges", rise_cnt, W);
    chk(bad_edge == 0, "R4 clock edge placement", bad_edge, 0);
    chk(bad_bit == 0, "R2 pull level per bit", bad_bit, 0);
    chk(cap == b, "R2 captured byte", int'(cap), int'(b));
    chk(sclk_out && !line_pull && !busy, "R12 idle after tx",
        {sclk_out, line_pull, busy}, 3'b100);
    @(negedge clk);
    chk(tx_done == 1'b1, "R5 tx_done sticky", tx_done, 1);
  endtask

  task automatic clear_tx();
    @(negedge clk); clr_tx_done = 1'b1;
    @(negedge clk); clr_tx_done = 1'b0;
    chk(tx_done == 1'b0, "R10 tx_done cleared", tx_done, 0);
  endtask

  task automatic run_rx(input logic [W-1:0] b);
    int cnt = 0, pulled = 0, moved = 0;
    @(negedge clk);
    dev_byte = b; dev_idx = '0; rise_cnt = 0; dev_active = 1'b1;
    rx_enable = 1'b1;
    @(negedge clk);
    while (!rx_done && cnt < 200) begin
      if (line_pull) pulled++;
      @(negedge clk);
      cnt++;
    end
    chk(cnt == XFER, "R6 cycles to rx_done", cnt, XFER);
    chk(rx_data == b, "R6 received byte", int'(rx_data), int'(b));
    chk(pulled == 0, "R7 line released in rx", pulled, 0);
    for (int i = 0; i < 2 * DIV; i++) begin
      @(negedge clk);
      if (!sclk_out || busy || rx_data != b) moved++;
    end
    chk(moved == 0, "R8 no restart while rx_done", moved, 0);
    rx_enable = 1'b0; dev_active = 1'b0;
    @(negedge clk); clr_rx_done = 1'b1;
    @(negedge clk); clr_rx_done = 1'b0;
    chk(rx_done == 1'b0, "R10 rx_done cleared", rx_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] dir [5] = '{8'h00, 8'hFF, 8'hA5, 8'h01, 8'h80};
    int unsigned seed = $urandom(32'd4242);
    int idle_bad = 0;
    repeat (3) @(negedge clk);
    chk({sclk_out, line_pull, tx_done, rx_done, busy} == 5'b10000, "R1 reset outputs",
        {sclk_out, line_pull, tx_done, rx_done, busy}, 5'b10000);
    chk(rx_data == '0, "R1 reset rx_data", int'(rx_data), 0);
    rst = 1'b0;
    @(negedge clk);
    foreach (dir[i]) begin run_tx(dir[i], 1'b0, -5, '0); clear_tx(); end
    foreach (dir[i]) run_rx(dir[i]);
    for (int i = 0; i < 8; i++) begin
      run_tx(W'($urandom), 1'b0, -5, '0); clear_tx();
      run_rx(W'($urandom));
    end
    // R9: a write during a transfer has no effect
    run_tx(8'h3C, 1'b0, 20, 8'hC3);
    clear_tx();
    for (int i = 0; i < 2 * DIV; i++) begin
      @(negedge clk);
      if (busy || tx_done || !sclk_out) idle_bad++;
    end
    chk(idle_bad == 0, "R9 no second transfer", idle_bad, 0);
    // R11: a write and a receive start in the same cycle
    run_tx(8'h6E, 1'b1, -5, '0);
    chk(rx_done == 1'b0, "R11 write wins over receive", rx_done, 0);
    clear_tx();
    summary();
    $finish;
  end
endmodule